// File: doc/BRIEF.md
# Time-Shared FIR Filter with Output Handshake

This block is a finite impulse response filter that computes every output with one multiplier and one accumulator, reused across all taps over consecutive clock cycles. A producer offers a signed sample with a one-cycle strobe while the block signals that it is ready. The block stores the sample in a circular history buffer and then walks a tap counter across that history and a constant coefficient table. It accumulates one product per cycle and places the finished sum in an output register.

The output register stays valid, with a steady value, until the consumer acknowledges it. Only after that acknowledge does the block accept another sample. Throughput is therefore at most one sample per TAPS+3 cycles. Any extra cycles the consumer takes to acknowledge lengthen the interval between samples.

The history buffer starts at zero. The first outputs therefore match a filter whose earlier inputs were all zero.

Top module: `tdm_fir`

## Requirements
- R1: After reset, out_valid is 0, out_sample is 0, in_ready is 1, and every history entry reads as zero.
- R2: in_ready is high only while the block waits for a sample. A strobe seen while in_ready is high is accepted, and in_ready is low in the following cycle.
- R3: Each output equals y(k) = sum over i=0..TAPS-1 of b(i)·x(k−i). Samples and outputs are two's complement. The coefficients are b(i) = i+1 for even i and −(i+1) for odd i.
- R4: out_valid rises exactly TAPS+1 clock edges after the edge that accepted the sample.
- R5: While out_valid is high and out_ack is low, out_valid stays high and out_sample does not change.
- R6: out_ack seen while out_valid is high clears out_valid and raises in_ready in the following cycle.
- R7: A strobe that arrives while in_ready is low has no effect: its sample never enters the history.
- R8: out_ack while no output is valid has no effect on out_valid, in_ready or later results.
- R9: The output width holds the full-scale result without overflow for any input sequence.
- R10: The accumulator is cleared before each sample, so no output carries any part of the previous sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sample | input | DW | Signed input sample |
| in_strobe | input | 1 | New-sample strobe, taken only while in_ready is high |
| in_ready | output | 1 | High while the block waits for a sample |
| out_sample | output | DW+CW+clog2(TAPS) | Signed filter result |
| out_valid | output | 1 | Result is present and held |
| out_ack | input | 1 | Consumer acknowledge of the held result |

## Verification
An impulse separates the coefficients by tap and shows their order and signs. A long run of ones exposes a reversed or stale history read through the running sum. Alternating full-scale values, aligned with the coefficient signs, drive the result to its largest magnitude and would expose a sign or width error. Pseudo-random samples with varied acknowledge delays, stray strobes during computation and stray acknowledges while idle are compared against a convolution kept in the bench. They separate correct pointer wrap, accumulator clearing and handshake gating from off-by-one faults.

// File: rtl/tdm_fir_pkg.sv
package tdm_fir_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_STORE = 2'd1,
    ST_MAC = 2'd2,
    ST_HOLD = 2'd3
  } fir_state_t;

  // Coefficient rule: +(i+1) on even taps, -(i+1) on odd taps
  function automatic int tap_coef(input int i);
    return (i % 2 == 0) ? (i + 1) : -(i + 1);
  endfunction
endpackage

// File: rtl/tdm_fir_coef_rom.sv
module tdm_fir_coef_rom #(
  parameter int TAPS = 5,
  parameter int CW = 8,
  localparam int IW = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic [IW-1:0]        addr,
  output logic signed [CW-1:0] coef
);
  import tdm_fir_pkg::*;

  logic signed [CW-1:0] table_q [TAPS];

  for (genvar g = 0; g < TAPS; g++) begin : g_tab
    assign table_q[g] = CW'(tap_coef(g));
  end

  always_comb begin
    coef = '0;
    for (int i = 0; i < TAPS; i++) begin
      if (addr == IW'(i)) coef = table_q[i];
    end
  end
endmodule

// File: rtl/tdm_fir_hist.sv
module tdm_fir_hist #(
  parameter int TAPS = 5,
  parameter int DW = 8,
  localparam int IW = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [IW-1:0]        waddr,
  input  logic signed [DW-1:0] wdata,
  input  logic [IW-1:0]        raddr,
  output logic signed [DW-1:0] rdata
);
  logic signed [DW-1:0] mem [TAPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < TAPS; i++) begin
      if (raddr == IW'(i)) rdata = mem[i];
    end
  end
endmodule

// File: rtl/tdm_fir_ctrl.sv
module tdm_fir_ctrl #(
  parameter int TAPS = 5,
  localparam int IW = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_strobe,
  input  logic          out_ack,
  output logic          capture,
  output logic          hist_we,
  output logic [IW-1:0] hist_waddr,
  output logic [IW-1:0] hist_raddr,
  output logic [IW-1:0] tap,
  output logic          acc_clr,
  output logic          acc_en,
  output logic          res_load,
  output logic          res_drop,
  output logic          ready
);
  import tdm_fir_pkg::*;

  localparam logic [IW-1:0] LAST = IW'(TAPS - 1);

  fir_state_t st, st_nxt;
  logic [IW-1:0] wptr, wptr_nxt;

  always_comb begin
    st_nxt = st;
    case (st)
      ST_WAIT:  if (in_strobe) st_nxt = ST_STORE;
      ST_STORE: st_nxt = ST_MAC;
      ST_MAC:   if (tap == LAST) st_nxt = ST_HOLD;
      ST_HOLD:  if (out_ack) st_nxt = ST_WAIT;
      default:  st_nxt = ST_WAIT;
    endcase
  end

  assign wptr_nxt   = (wptr == LAST) ? '0 : wptr + 1'b1;
  assign capture    = (st == ST_WAIT) && in_strobe;
  assign hist_we    = (st == ST_STORE);
  assign hist_waddr = wptr_nxt;
  assign acc_clr    = (st == ST_STORE);
  assign acc_en     = (st == ST_MAC);
  assign res_load   = (st == ST_MAC) && (tap == LAST);
  assign res_drop   = (st == ST_HOLD) && out_ack;
  // newest sample minus tap index, modulo TAPS
  assign hist_raddr = (wptr >= tap) ? (wptr - tap) : IW'(32'(wptr) + TAPS - 32'(tap));

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_WAIT;
      tap   <= '0;
      wptr  <= '0;
      ready <= 1'b1;
    end else begin
      st    <= st_nxt;
      ready <= (st_nxt == ST_WAIT);
      if (st == ST_STORE) begin
        wptr <= wptr_nxt;
        tap  <= '0;
      end else if (st == ST_MAC && tap != LAST) begin
        tap <= tap + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdm_fir_mac.sv
module tdm_fir_mac #(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int AW = 19,
  localparam int PW = DW + CW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 en,
  input  logic                 load,
  input  logic                 drop,
  input  logic signed [CW-1:0] coef,
  input  logic signed [DW-1:0] samp,
  output logic signed [AW-1:0] result,
  output logic                 valid
);
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] acc, sum;

  assign prod = coef * samp;
  assign sum  = acc + {{(AW-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      result <= '0;
      valid  <= 1'b0;
    end else begin
      if (clr)      acc <= '0;
      else if (en)  acc <= sum;
      if (load) begin
        result <= sum;
        valid  <= 1'b1;
      end else if (drop) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tdm_fir.sv
module tdm_fir #(
  parameter int TAPS = 5,
  parameter int DW = 8,
  parameter int CW = 8,
  localparam int IW = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int OW = DW + CW + IW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] in_sample,
  input  logic                 in_strobe,
  output logic                 in_ready,
  output logic signed [OW-1:0] out_sample,
  output logic                 out_valid,
  input  logic                 out_ack
);
  logic          capture, hist_we, acc_clr, acc_en, res_load, res_drop;
  logic [IW-1:0] waddr, raddr, tap;
  logic signed [DW-1:0] in_q, hist_q;
  logic signed [CW-1:0] coef;

  always_ff @(posedge clk) begin
    if (rst)          in_q <= '0;
    else if (capture) in_q <= in_sample;
  end

  tdm_fir_ctrl #(.TAPS(TAPS)) u_ctrl (
    .clk(clk), .rst(rst), .in_strobe(in_strobe), .out_ack(out_ack),
    .capture(capture), .hist_we(hist_we), .hist_waddr(waddr),
    .hist_raddr(raddr), .tap(tap), .acc_clr(acc_clr), .acc_en(acc_en),
    .res_load(res_load), .res_drop(res_drop), .ready(in_ready)
  );

  tdm_fir_hist #(.TAPS(TAPS), .DW(DW)) u_hist (
    .clk(clk), .rst(rst), .we(hist_we), .waddr(waddr), .wdata(in_q),
    .raddr(raddr), .rdata(hist_q)
  );

  tdm_fir_coef_rom #(.TAPS(TAPS), .CW(CW)) u_rom (
    .addr(tap), .coef(coef)
  );

  tdm_fir_mac #(.DW(DW), .CW(CW), .AW(OW)) u_mac (
    .clk(clk), .rst(rst), .clr(acc_clr), .en(acc_en), .load(res_load),
    .drop(res_drop), .coef(coef), .samp(hist_q), .result(out_sample),
    .valid(out_valid)
  );
endmodule

// File: rtl/tdm_fir_chk.sv
module tdm_fir_chk #(
  parameter int TAPS = 5,
  parameter int DW = 8,
  parameter int OW = 19
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_strobe,
  input logic                 in_ready,
  input logic signed [OW-1:0] out_sample,
  input logic                 out_valid,
  input logic                 out_ack
);
  function automatic longint peak_mag();
    longint s = 0;
    for (int i = 0; i < TAPS; i++) s += longint'(i + 1);
    return s * (longint'(1) << (DW - 1));
  endfunction

  localparam longint PEAK = peak_mag();

  int unsigned since_accept;
  always_ff @(posedge clk) begin
    if (rst) since_accept <= 0;
    else if (in_ready && in_strobe) since_accept <= 1;
    else if (since_accept != 0 && !out_valid) since_accept <= since_accept + 1;
  end

  p_ready_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));
  p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (rst)
    in_ready && in_strobe |=> !in_ready);
  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> since_accept == TAPS + 2);
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ack |=> out_valid && $stable(out_sample));
  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ack |=> !out_valid && in_ready);
  p_idle_ack_r8: assert property (@(posedge clk) disable iff (rst)
    !out_valid && in_ready && !in_strobe |=> !out_valid && in_ready);
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (longint'(out_sample) <= PEAK) && (longint'(out_sample) >= -PEAK));
endmodule

bind tdm_fir tdm_fir_chk #(.TAPS(TAPS), .DW(DW), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .in_strobe(in_strobe), .in_ready(in_ready),
  .out_sample(out_sample), .out_valid(out_valid), .out_ack(out_ack)
);

// File: tb/tdm_fir_test.sv
module tdm_fir_test;
  localparam int TAPS = 5;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int OW = DW + CW + $clog2(TAPS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [DW-1:0] in_sample = '0;
  logic in_strobe = 1'b0;
  logic in_ready;
  logic signed [OW-1:0] out_sample;
  logic out_valid;
  logic out_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  int hist [TAPS];
  bit done = 1'b0;

  always #4 clk = ~clk;

  tdm_fir #(.TAPS(TAPS), .DW(DW), .CW(CW)) uut (
    .clk(clk), .rst(rst), .in_sample(in_sample), .in_strobe(in_strobe),
    .in_ready(in_ready), .out_sample(out_sample), .out_valid(out_valid),
    .out_ack(out_ack)
  );

  function automatic int bcoef(input int i);
    return (i % 2 == 0) ? (i + 1) : -(i + 1);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // feed one sample, verify latency, result, hold and release
  task automatic feed(input int x, input int hold, input bit stray);
    int exp;
    @(negedge clk);
    check("R2 ready before strobe", in_ready, 1);
    in_sample = DW'(x);
    in_strobe = 1'b1;
    @(negedge clk);
    in_strobe = 1'b0;
    check("R2 ready low after accept", in_ready, 0);
    for (int i = TAPS - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = x;
    exp = 0;
    for (int i = 0; i < TAPS; i++) exp += bcoef(i) * hist[i];
    for (int j = 1; j <= TAPS; j++) begin
      if (stray && j == 2) begin
        in_sample = DW'(x + 77);
        in_strobe = 1'b1;
      end
      @(negedge clk);
      in_strobe = 1'b0;
      check("R4 not yet valid", out_valid, 0);
    end
    @(negedge clk);
    check("R4 valid on time", out_valid, 1);
    check("R3 R10 result", longint'(out_sample), exp);
    for (int h = 0; h < hold; h++) begin
      if (stray && h == 0) begin
        in_sample = 8'sd55;
        in_strobe = 1'b1;
      end
      @(negedge clk);
      in_strobe = 1'b0;
      check("R5 valid held", out_valid, 1);
      check("R5 value held", longint'(out_sample), exp);
    end
    out_ack = 1'b1;
    @(negedge clk);
    out_ack = 1'b0;
    check("R6 valid cleared", out_valid, 0);
    check("R6 ready restored", in_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < TAPS; i++) hist[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", out_valid, 0);
    check("R1 sample after reset", longint'(out_sample), 0);
    check("R1 ready after reset", in_ready, 1);

    // R8: acknowledge while idle
    out_ack = 1'b1;
    repeat (3) @(negedge clk);
    out_ack = 1'b0;
    check("R8 valid stays low", out_valid, 0);
    check("R8 ready stays high", in_ready, 1);

    // impulse: R1 zero history and R3 coefficient order
    feed(1, 0, 1'b0);
    for (int k = 0; k < TAPS; k++) feed(0, 1, 1'b0);

    // step
    for (int k = 0; k < TAPS + 2; k++) feed(1, 0, 1'b0);

    // R9 full scale aligned with coefficient signs
    for (int k = 0; k < 2 * TAPS; k++) feed((k % 2 == 0) ? 127 : -128, 0, 1'b0);
    for (int k = 0; k < 2 * TAPS; k++) feed((k % 2 == 0) ? -128 : 127, 0, 1'b0);
    for (int k = 0; k < TAPS + 1; k++) feed(-128, 0, 1'b0);

    // R7 stray strobes and R10 random traffic
    for (int k = 0; k < 60; k++) begin
      int v;
      v = int'($urandom_range(255)) - 128;
      feed(v, int'($urandom_range(4)), (k % 3) == 0);
      if (k % 7 == 0) begin
        out_ack = 1'b1;
        @(negedge clk);
        out_ack = 1'b0;
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule